// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This peripheral sits on a simple synchronous word bus and gives software a 16x16 multiplier through a handful of word registers. Software picks the operation by choosing which of three first-operand addresses it writes: one selects an unsigned product, one a two's-complement product, and one an unsigned product that is summed into the running result. Writing the second operand performs the operation at once. The 32-bit outcome is split across a low and a high result word, and the result is readable on the very next bus cycle.

Both result words can also be written by software. This allows a longer product to be built in pieces. Software moves the high word of one partial product into the low word, clears the high word, and then lets later accumulate operations add further partial products on top. The selected mode and the first operand stay in place until they are rewritten, so a series of second-operand writes reuses them.

Top module: `mac_periph`

## Requirements
- R1: After reset, every register reads as zero and the unsigned mode is selected.
- R2: A write to offset 0x00, 0x02 or 0x04 stores the first operand and selects unsigned, signed or accumulate mode, in that order; it leaves both result words unchanged.
- R3: In unsigned mode, a write to offset 0x08 places the 32-bit unsigned product in the result words (low half at 0x0A, high half at 0x0C), readable on the next bus cycle.
- R4: In signed mode, a write to offset 0x08 places the 32-bit two's-complement product of both operands in the result words.
- R5: In accumulate mode, a write to offset 0x08 adds the 32-bit unsigned product to the 32-bit value held in the result words.
- R6: Bus writes to 0x0A and 0x0C load the low and high result words; a later accumulate adds onto the loaded value, so a 32x32 product's low 32 bits can be chained from 16-bit partial products.
- R7: The mode and the first operand are kept across any number of writes to offset 0x08; the mode only ever holds one of the three defined values.
- R8: Reading 0x00, 0x02 or 0x04 returns the stored first operand; reading 0x08 returns the last second operand written.
- R9: Reads of any other offset return zero, and writes to them change no register.
- R10: Accumulation wraps modulo 2^32, with no carry or overflow indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, valid in the cycle of the read; zero when not reading |

## Verification
On every cycle the checker recomputes the product in its own form after each second-operand write for all three modes, confirms that first-operand and unmapped writes leave the result and operand state untouched, that unmapped reads return zero, and that the mode stays legal. Only the bench's scenarios can show the reset values at the ports, the read-back of every operand address, the reuse of a mode across repeated starts, the wrap of the accumulator, and the chaining of partial products into a 32x32 result through software-loaded result words. The bench sweeps a set of corner operands through every mode and compares against products it computes arithmetically.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        MODE_UNS = 2'd0,
        MODE_SGN = 2'd1,
        MODE_ACC = 2'd2
    } mode_t;

    localparam int NREG    = 6;
    localparam int IX_OP1U = 0;
    localparam int IX_OP1S = 1;
    localparam int IX_OP1A = 2;
    localparam int IX_OP2  = 3;
    localparam int IX_RESL = 4;
    localparam int IX_RESH = 5;

    localparam logic [7:0] OFF_OP1U = 8'h00;
    localparam logic [7:0] OFF_OP1S = 8'h02;
    localparam logic [7:0] OFF_OP1A = 8'h04;
    localparam logic [7:0] OFF_OP2  = 8'h08;
    localparam logic [7:0] OFF_RESL = 8'h0A;
    localparam logic [7:0] OFF_RESH = 8'h0C;

    function automatic logic [7:0] reg_offset(input int idx);
        case (idx)
            IX_OP1U: reg_offset = OFF_OP1U;
            IX_OP1S: reg_offset = OFF_OP1S;
            IX_OP1A: reg_offset = OFF_OP1A;
            IX_OP2:  reg_offset = OFF_OP2;
            IX_RESL: reg_offset = OFF_RESL;
            default: reg_offset = OFF_RESH;
        endcase
    endfunction

endpackage

// File: rtl/mac_addr_dec.sv
module mac_addr_dec
    import mac_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);
    for (genvar gi = 0; gi < NREG; gi++) begin : g_hit
        localparam logic [7:0] OFFS = reg_offset(gi);
        assign hit[gi] = (addr == OFFS[ADDR_W-1:0]);
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                as_signed,
    output logic [2*DATA_W-1:0] prod
);
    localparam int EXT_W = DATA_W + 1;
    localparam int FULL_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  ea;
    logic signed [EXT_W-1:0]  eb;
    logic signed [FULL_W-1:0] full;

    always_comb begin
        ea   = $signed({as_signed & opa[DATA_W-1], opa});
        eb   = $signed({as_signed & opb[DATA_W-1], opb});
        full = FULL_W'(ea) * FULL_W'(eb);
        prod = full[2*DATA_W-1:0];
    end
endmodule

// File: rtl/mac_sum.sv
module mac_sum #(
    parameter int RES_W = 32
) (
    input  logic [RES_W-1:0] base,
    input  logic [RES_W-1:0] addend,
    input  logic             add_en,
    output logic [RES_W-1:0] sum
);
    always_comb begin
        sum = add_en ? (base + addend) : addend;
    end
endmodule

// File: rtl/mac_periph.sv
module mac_periph
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int RES_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] op2;
        mode_t             mode;
        logic [RES_W-1:0]  res;
    } regs_t;

    regs_t st_q;
    regs_t st_d;

    logic [NREG-1:0]  hit;
    logic [RES_W-1:0] prod;
    logic [RES_W-1:0] new_res;
    logic             wr_en;
    logic             rd_en;

    mac_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    mac_mult #(.DATA_W(DATA_W)) u_mult (
        .opa       (st_q.op1),
        .opb       (bus_wdata),
        .as_signed (st_q.mode == MODE_SGN),
        .prod      (prod)
    );

    mac_sum #(.RES_W(RES_W)) u_sum (
        .base   (st_q.res),
        .addend (prod),
        .add_en (st_q.mode == MODE_ACC),
        .sum    (new_res)
    );

    always_comb begin
        st_d      = st_q;
        wr_en     = bus_sel & bus_wr;
        rd_en     = bus_sel & ~bus_wr;
        bus_rdata = '0;

        if (wr_en) begin
            if (hit[IX_OP1U]) begin
                st_d.op1  = bus_wdata;
                st_d.mode = MODE_UNS;
            end else if (hit[IX_OP1S]) begin
                st_d.op1  = bus_wdata;
                st_d.mode = MODE_SGN;
            end else if (hit[IX_OP1A]) begin
                st_d.op1  = bus_wdata;
                st_d.mode = MODE_ACC;
            end else if (hit[IX_OP2]) begin
                st_d.op2 = bus_wdata;
                st_d.res = new_res;
            end else if (hit[IX_RESL]) begin
                st_d.res[DATA_W-1:0] = bus_wdata;
            end else if (hit[IX_RESH]) begin
                st_d.res[RES_W-1:DATA_W] = bus_wdata;
            end
        end

        if (rd_en) begin
            if (hit[IX_OP1U] | hit[IX_OP1S] | hit[IX_OP1A]) begin
                bus_rdata = st_q.op1;
            end else if (hit[IX_OP2]) begin
                bus_rdata = st_q.op2;
            end else if (hit[IX_RESL]) begin
                bus_rdata = st_q.res[DATA_W-1:0];
            end else if (hit[IX_RESH]) begin
                bus_rdata = st_q.res[RES_W-1:DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk
    import mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] op1_q,
    input logic [1:0]        mode_q,
    input logic [2*DATA_W-1:0] res_q
);
    localparam int RW = 2 * DATA_W;

    function automatic logic [RW-1:0] zx(input logic [DATA_W-1:0] v);
        return {{DATA_W{1'b0}}, v};
    endfunction

    function automatic logic [RW-1:0] sx(input logic [DATA_W-1:0] v);
        return {{DATA_W{v[DATA_W-1]}}, v};
    endfunction

    logic mapped;
    logic wr_op1;
    logic wr_op2;
    always_comb begin
        mapped = (bus_addr == OFF_OP1U[ADDR_W-1:0]) || (bus_addr == OFF_OP1S[ADDR_W-1:0]) ||
                 (bus_addr == OFF_OP1A[ADDR_W-1:0]) || (bus_addr == OFF_OP2[ADDR_W-1:0])  ||
                 (bus_addr == OFF_RESL[ADDR_W-1:0]) || (bus_addr == OFF_RESH[ADDR_W-1:0]);
        wr_op1 = bus_sel && bus_wr && ((bus_addr == OFF_OP1U[ADDR_W-1:0]) ||
                 (bus_addr == OFF_OP1S[ADDR_W-1:0]) || (bus_addr == OFF_OP1A[ADDR_W-1:0]));
        wr_op2 = bus_sel && bus_wr && (bus_addr == OFF_OP2[ADDR_W-1:0]);
    end

    assert_op1_keeps_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op1 |=> (res_q == $past(res_q)));

    assert_unsigned_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == 2'd0) |=> (res_q == zx($past(op1_q)) * zx($past(bus_wdata))));

    assert_signed_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == 2'd1) |=> (res_q == sx($past(op1_q)) * sx($past(bus_wdata))));

    assert_accumulate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == 2'd2) |=>
            (res_q == $past(res_q) + zx($past(op1_q)) * zx($past(bus_wdata))));

    assert_start_keeps_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op2 |=> ($stable(mode_q) && $stable(op1_q)));

    assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'd3);

    assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == '0));

    assert_unmapped_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !mapped) |=>
            ($stable(res_q) && $stable(op1_q) && $stable(mode_q)));

    assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel) |-> (bus_rdata == '0));
endmodule

bind mac_periph mac_periph_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .op1_q     (st_q.op1),
    .mode_q    (st_q.mode),
    .res_q     (st_q.res)
);

// File: tb/mac_periph_bench.sv
module mac_periph_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_OP1U = 4'h0;
    localparam logic [3:0] A_OP1S = 4'h2;
    localparam logic [3:0] A_OP1A = 4'h4;
    localparam logic [3:0] A_OP2  = 4'h8;
    localparam logic [3:0] A_RESL = 4'hA;
    localparam logic [3:0] A_RESH = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;

    mac_periph u_mac_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_res(output logic [31:0] r);
        logic [15:0] lo;
        logic [15:0] hi;
        rd(A_RESL, lo);
        rd(A_RESH, hi);
        r = {hi, lo};
    endtask

    function automatic logic [15:0] pick(input int i);
        case (i)
            0: pick = 16'h0000;
            1: pick = 16'h0001;
            2: pick = 16'h7FFF;
            3: pick = 16'h8000;
            4: pick = 16'hFFFF;
            5: pick = 16'h1234;
            6: pick = 16'hFFFE;
            default: pick = 16'h00C3;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] r;
        logic [31:0] acc;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [15:0] r0;
        logic [15:0] h;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_OP1U, v); chk("R1 op1", {16'h0, v}, 32'h0);
        rd(A_OP2, v);  chk("R1 op2", {16'h0, v}, 32'h0);
        rd_res(r);     chk("R1 result", r, 32'h0);
        wr(A_OP2, 16'h0005);
        rd_res(r);     chk("R1 unsigned mode after reset", r, 32'h0);

        // R3: unsigned sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                wr(A_OP1U, pick(i));
                wr(A_OP2, pick(j));
                rd_res(r);
                chk("R3 unsigned product", r, {16'h0, pick(i)} * {16'h0, pick(j)});
            end
        end

        // R4: signed sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                wr(A_OP1S, pick(i));
                wr(A_OP2, pick(j));
                rd_res(r);
                chk("R4 signed product", r,
                    32'(int'($signed(pick(i))) * int'($signed(pick(j)))));
            end
        end

        // R5 / R6: accumulate sweep starting from software-loaded result
        wr(A_RESL, 16'hBEEF);
        wr(A_RESH, 16'h0102);
        acc = 32'h0102BEEF;
        rd_res(r); chk("R6 result words writable", r, acc);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                wr(A_OP1A, pick(i));
                wr(A_OP2, pick(j));
                acc = acc + {16'h0, pick(i)} * {16'h0, pick(j)};
                rd_res(r);
                chk("R5 accumulate", r, acc);
            end
        end

        // R2: operand-1 write leaves the result alone
        rd_res(acc);
        wr(A_OP1S, 16'h4321);
        rd_res(r); chk("R2 op1 write keeps result", r, acc);

        // R8: operand read-back
        rd(A_OP1U, v); chk("R8 op1 at 0x00", {16'h0, v}, 32'h4321);
        rd(A_OP1S, v); chk("R8 op1 at 0x02", {16'h0, v}, 32'h4321);
        rd(A_OP1A, v); chk("R8 op1 at 0x04", {16'h0, v}, 32'h4321);
        wr(A_OP2, 16'h0002);
        rd(A_OP2, v);  chk("R8 op2 read", {16'h0, v}, 32'h0002);

        // R7: signed mode and op1 reused across starts
        wr(A_OP1S, 16'hFFFF);
        wr(A_OP2, 16'h0003);
        rd_res(r); chk("R7 first start", r, 32'hFFFFFFFD);
        wr(A_OP2, 16'h0005);
        rd_res(r); chk("R7 repeated start reuses mode", r, 32'hFFFFFFFB);
        wr(A_OP2, 16'h8000);
        rd_res(r); chk("R7 third start", r, 32'h00008000);

        // R10: wrap of the accumulator
        wr(A_RESL, 16'hFFFF);
        wr(A_RESH, 16'hFFFF);
        wr(A_OP1A, 16'h0001);
        wr(A_OP2, 16'h0002);
        rd_res(r); chk("R10 wrap", r, 32'h00000001);
        wr(A_OP2, 16'hFFFF);
        rd_res(r); chk("R10 second add", r, 32'h00010000);

        // R9: unmapped offsets
        rd_res(acc);
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 2 || a == 4 || a == 8 || a == 10 || a == 12) continue;
            wr(4'(a), 16'hA5A5);
            rd(4'(a), v); chk("R9 unmapped read zero", {16'h0, v}, 32'h0);
        end
        rd_res(r); chk("R9 unmapped writes keep result", r, acc);
        rd(A_OP1U, v); chk("R9 unmapped writes keep op1", {16'h0, v}, 32'h0001);
        wr(A_OP2, 16'h0001);
        rd_res(r); chk("R9 mode still accumulate", r, acc + 32'h1);

        // R6: 32x32 low word chained through partial products
        ea = 32'h12345678;
        eb = 32'h9ABCDEF0;
        wr(A_OP1U, ea[15:0]);
        wr(A_OP2, eb[15:0]);
        rd(A_RESL, r0);
        rd(A_RESH, h);
        wr(A_RESL, h);
        wr(A_RESH, 16'h0);
        wr(A_OP1A, ea[15:0]);
        wr(A_OP2, eb[31:16]);
        wr(A_OP1A, ea[31:16]);
        wr(A_OP2, eb[15:0]);
        rd(A_RESL, v);
        chk("R6 chained 32x32 product", {v, r0}, ea * eb);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule